// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block is the digital control front end of a PLL-based clock generator. It holds two programmable fields. The first is a 5-bit multiplier ratio, where zero means the oscillator bypasses the PLL and 1 to 18 multiply the oscillator frequency. The second is a 2-bit post-divider select. The block enforces the safe programming order between the two fields. The ratio may only be changed while the post-divider sits at its slowest setting. The post-divider may only be sped up once the PLL reports lock.

Every accepted ratio write clears the lock status and starts a lock timer. A cycle counter stands in for the analog settling time. Lock is reported again once the programmed number of cycles has passed. Writes take effect only while a write-protect enable input is high. Four reset inputs exist. The external and watchdog resets return the fields to defaults. The debugger and missing-clock resets leave the fields untouched and only clear the read-data register. The multiplier code, divider code, effective divide, bypass flag, lock flag and a sticky error flag are all driven from registers.

Top module: `clkseq_ctrl`

## Requirements
- R1: On `rst_ext` or `rst_wdog` (synchronous, active high) the block returns to these defaults: ratio 0, divider select 0, `eff_div` 4, `bypass` 1, `locked` 1, `err_flag` 0, `rd_data` 0.
- R2: `rst_dbg` and `rst_mclk` leave ratio, divider select, lock state and error flag unchanged; they only clear `rd_data` to 0.
- R3: A write (`wr_en` high) changes nothing, including the error flag, unless `prot_en` is high in the same cycle.
- R4: A ratio write (`wr_sel` = 0, value in `wr_data[4:0]`) is accepted only while the divider select is 0; otherwise it is ignored.
- R5: A ratio value above 18 is rejected, leaves the ratio unchanged, and sets `err_flag`. The flag stays set until an external or watchdog reset.
- R6: After an accepted ratio write at clock edge E0, `locked` reads 0 after edges E1 through E(LOCK_CYCLES) and reads 1 from edge E(LOCK_CYCLES+1) on.
- R7: An accepted ratio write while the lock timer runs restarts the count from zero.
- R8: A divider write (`wr_sel` = 1, value in `wr_data[1:0]`) to a nonzero value is accepted only while the lock status is 1; writing 0 is always accepted.
- R9: `eff_div` is 4 for divider select 0 or 1, 2 for select 2, and 1 for select 3; `bypass` is 1 exactly when the ratio is 0.
- R10: `rd_data` one cycle after `rd_sel` = 0 holds the ratio in bits 4:0. After `rd_sel` = 1 it holds the divider select in bits 1:0, the lock status in bit 6 and the error flag in bit 7. All other bits are 0.
- R11: `mult_code`, `div_code`, `eff_div`, `bypass`, `locked` and `err_flag` change one clock after the internal state they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext | input | 1 | External reset, clears all state |
| rst_wdog | input | 1 | Watchdog reset, clears all state |
| rst_dbg | input | 1 | Debugger reset, clears read data only |
| rst_mclk | input | 1 | Missing-clock reset, clears read data only |
| prot_en | input | 1 | Write-protect enable; writes act only when high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 ratio, 1 divider select |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Read target: 0 ratio, 1 status |
| rd_data | output | 8 | Registered read value |
| mult_code | output | 5 | Multiplier code to the PLL |
| div_code | output | 2 | Divider select to the output divider |
| eff_div | output | 3 | Effective divide factor (1, 2 or 4) |
| bypass | output | 1 | PLL bypassed (ratio 0) |
| locked | output | 1 | Lock status |
| err_flag | output | 1 | Sticky out-of-range ratio error |

## Verification
A wrong ordering gate would show up at `mult_code` one cycle after a ratio write that should have been blocked, or at `div_code` after a divider write issued while unlocked. A lock counter that is off by even one cycle makes `locked` read the wrong value at edge LOCK_CYCLES or LOCK_CYCLES+1 after the write. The bench samples exactly at those two edges, and it samples the restart case the same way. A reset source with the wrong reach shows up either as a lost ratio or divider value on the next cycle after a debugger or missing-clock pulse, or as stale values after an external or watchdog reset.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic {
    SEL_RATIO = 1'b0,
    SEL_DIV   = 1'b1
  } reg_sel_e;

  // Post-divide factor for a divider select code.
  function automatic logic [2:0] div_factor(input logic [1:0] code);
    logic [2:0] f;
    case (code)
      2'd2:    f = 3'd2;
      2'd3:    f = 3'd1;
      default: f = 3'd4;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/clkseq_regs.sv
module clkseq_regs
  import clkseq_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int DIV_W     = 2,
  parameter int DATA_W    = 8,
  parameter int RATIO_MAX = 18
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic               prot_en,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               lock_ok,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [DIV_W-1:0]   div_q,
  output logic               err_q,
  output logic               ratio_load
);

  localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(RATIO_MAX);

  logic [RATIO_W-1:0] ratio_val;
  logic [DIV_W-1:0]   div_val;
  logic               wr_gate;
  logic               ratio_try;
  logic               ratio_bad;
  logic               div_ok;

  always_comb begin
    ratio_val  = wr_data[RATIO_W-1:0];
    div_val    = wr_data[DIV_W-1:0];
    wr_gate    = wr_en && prot_en;
    ratio_try  = wr_gate && (wr_sel == SEL_RATIO) && (div_q == '0);
    ratio_load = ratio_try && (ratio_val <= RMAX);
    ratio_bad  = ratio_try && (ratio_val > RMAX);
    div_ok     = wr_gate && (wr_sel == SEL_DIV) && ((div_val == '0) || lock_ok);
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      ratio_q <= '0;
      div_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ratio_load) ratio_q <= ratio_val;
      if (ratio_bad)  err_q   <= 1'b1;
      if (div_ok)     div_q   <= div_val;
    end
  end

endmodule

// File: rtl/clkseq_lock.sv
module clkseq_lock #(
  parameter int LOCK_CYCLES = 100000
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic start,
  output logic locked
);

  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

  generate
    if (LOCK_CYCLES == 0) begin : g_instant
      always_ff @(posedge clk) begin
        if (hard_rst) locked <= 1'b1;
        else          locked <= 1'b1;
      end
    end else begin : g_timer
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (hard_rst) begin
          cnt    <= '0;
          locked <= 1'b1;
        end else if (start) begin
          cnt    <= '0;
          locked <= 1'b0;
        end else if (!locked) begin
          if (cnt == LAST) locked <= 1'b1;
          else             cnt    <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/clkseq_out.sv
module clkseq_out
  import clkseq_pkg::*;
#(
  parameter int RATIO_W = 5,
  parameter int DIV_W   = 2,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic               soft_rst,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic [DIV_W-1:0]   div_q,
  input  logic               err_q,
  input  logic               lock_q,
  input  logic               rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic [RATIO_W-1:0] mult_code,
  output logic [DIV_W-1:0]   div_code,
  output logic [2:0]         eff_div,
  output logic               bypass,
  output logic               locked,
  output logic               err_flag
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_sel == SEL_RATIO) begin
      rd_next[RATIO_W-1:0] = ratio_q;
    end else begin
      rd_next[DIV_W-1:0]  = div_q;
      rd_next[DATA_W-2]   = lock_q;
      rd_next[DATA_W-1]   = err_q;
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) rd_data <= '0;
    else                      rd_data <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      mult_code <= '0;
      div_code  <= '0;
      eff_div   <= 3'd4;
      bypass    <= 1'b1;
      locked    <= 1'b1;
      err_flag  <= 1'b0;
    end else begin
      mult_code <= ratio_q;
      div_code  <= div_q;
      eff_div   <= div_factor(div_q);
      bypass    <= (ratio_q == '0);
      locked    <= lock_q;
      err_flag  <= err_q;
    end
  end

endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter int RATIO_W     = 5,
  parameter int DIV_W       = 2,
  parameter int DATA_W      = 8,
  parameter int RATIO_MAX   = 18,
  parameter int LOCK_CYCLES = 100000
) (
  input  logic               clk,
  input  logic               rst_ext,
  input  logic               rst_wdog,
  input  logic               rst_dbg,
  input  logic               rst_mclk,
  input  logic               prot_en,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic [RATIO_W-1:0] mult_code,
  output logic [DIV_W-1:0]   div_code,
  output logic [2:0]         eff_div,
  output logic               bypass,
  output logic               locked,
  output logic               err_flag
);

  logic               hard_rst;
  logic               soft_rst;
  logic [RATIO_W-1:0] ratio_q;
  logic [DIV_W-1:0]   div_q;
  logic               err_q;
  logic               ratio_load;
  logic               lock_q;

  assign hard_rst = rst_ext || rst_wdog;
  assign soft_rst = rst_dbg || rst_mclk;

  clkseq_regs #(
    .RATIO_W  (RATIO_W),
    .DIV_W    (DIV_W),
    .DATA_W   (DATA_W),
    .RATIO_MAX(RATIO_MAX)
  ) u_regs (
    .clk       (clk),
    .hard_rst  (hard_rst),
    .prot_en   (prot_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .lock_ok   (lock_q),
    .ratio_q   (ratio_q),
    .div_q     (div_q),
    .err_q     (err_q),
    .ratio_load(ratio_load)
  );

  clkseq_lock #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk     (clk),
    .hard_rst(hard_rst),
    .start   (ratio_load),
    .locked  (lock_q)
  );

  clkseq_out #(
    .RATIO_W(RATIO_W),
    .DIV_W  (DIV_W),
    .DATA_W (DATA_W)
  ) u_out (
    .clk      (clk),
    .hard_rst (hard_rst),
    .soft_rst (soft_rst),
    .ratio_q  (ratio_q),
    .div_q    (div_q),
    .err_q    (err_q),
    .lock_q   (lock_q),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .mult_code(mult_code),
    .div_code (div_code),
    .eff_div  (eff_div),
    .bypass   (bypass),
    .locked   (locked),
    .err_flag (err_flag)
  );

endmodule

// File: rtl/clkseq_ctrl_chk.sv
module clkseq_ctrl_chk #(
  parameter int RATIO_W   = 5,
  parameter int DIV_W     = 2,
  parameter int RATIO_MAX = 18
) (
  input logic               clk,
  input logic               hard_rst,
  input logic               soft_rst,
  input logic               prot_en,
  input logic               wr_en,
  input logic [RATIO_W-1:0] ratio_q,
  input logic [DIV_W-1:0]   div_q,
  input logic               err_q,
  input logic               lock_q,
  input logic [RATIO_W-1:0] mult_code,
  input logic               locked
);

  // R4: the ratio moves only while the divider sat at its slowest setting
  assert_ratio_order_R4: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && ratio_q != $past(ratio_q)) |-> ($past(div_q) == '0));

  // R8: the divider leaves zero only from a locked state
  assert_div_lock_R8: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && div_q != $past(div_q) && div_q != '0) |-> $past(lock_q));

  // R3: nothing changes without the protect enable
  assert_protect_R3: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && !$past(prot_en)) |->
      ($stable(ratio_q) && $stable(div_q) && $stable(err_q)));

  // R5: ratio never holds an out-of-range value; the error flag is sticky
  assert_ratio_range_R5: assert property (@(posedge clk) disable iff (hard_rst)
    ratio_q <= RATIO_W'(RATIO_MAX));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && $past(err_q)) |-> err_q);

  // R6: a ratio change drops the lock status
  assert_relock_R6: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && ratio_q != $past(ratio_q)) |-> !lock_q);

  // R2: a soft reset without a write keeps the fields
  assert_soft_keep_R2: assert property (@(posedge clk) disable iff (hard_rst)
    (!$past(hard_rst) && $past(soft_rst) && !$past(wr_en)) |->
      ($stable(ratio_q) && $stable(div_q) && $stable(err_q)));

  // R11: outputs follow the internal state one cycle later
  assert_out_lag_R11: assert property (@(posedge clk) disable iff (hard_rst)
    !$past(hard_rst) |-> (mult_code == $past(ratio_q) && locked == $past(lock_q)));

endmodule

bind clkseq_ctrl clkseq_ctrl_chk #(
  .RATIO_W  (RATIO_W),
  .DIV_W    (DIV_W),
  .RATIO_MAX(RATIO_MAX)
) u_chk (
  .clk      (clk),
  .hard_rst (hard_rst),
  .soft_rst (soft_rst),
  .prot_en  (prot_en),
  .wr_en    (wr_en),
  .ratio_q  (ratio_q),
  .div_q    (div_q),
  .err_q    (err_q),
  .lock_q   (lock_q),
  .mult_code(mult_code),
  .locked   (locked)
);

// File: tb/clkseq_ctrl_bench.sv
`timescale 1ns/1ps
module clkseq_ctrl_bench;

  localparam int L = 16;

  logic       clk = 1'b0;
  logic       rst_ext = 1'b1;
  logic       rst_wdog = 1'b0;
  logic       rst_dbg = 1'b0;
  logic       rst_mclk = 1'b0;
  logic       prot_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] mult_code;
  logic [1:0] div_code;
  logic [2:0] eff_div;
  logic       bypass;
  logic       locked;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_ratio = 0;
  int exp_div = 0;
  int exp_err = 0;

  always #5 clk = ~clk;

  clkseq_ctrl #(.LOCK_CYCLES(L)) u_clkseq_ctrl (
    .clk(clk), .rst_ext(rst_ext), .rst_wdog(rst_wdog), .rst_dbg(rst_dbg),
    .rst_mclk(rst_mclk), .prot_en(prot_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mult_code(mult_code), .div_code(div_code), .eff_div(eff_div),
    .bypass(bypass), .locked(locked), .err_flag(err_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_eff(input int d);
    return (d < 2) ? 4 : ((d == 2) ? 2 : 1);
  endfunction

  task automatic check_state(input string req);
    check({req, " mult_code"}, int'(mult_code), exp_ratio);
    check({req, " div_code"}, int'(div_code), exp_div);
    check({req, " eff_div R9"}, int'(eff_div), exp_eff(exp_div));
    check({req, " bypass R9"}, int'(bypass), (exp_ratio == 0) ? 1 : 0);
    check({req, " err_flag"}, int'(err_flag), exp_err);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive one write through edge E0; returns at the falling edge after E0.
  task automatic do_write(input logic sel, input int d, input logic p);
    wr_en = 1'b1; wr_sel = sel; wr_data = 8'(d); prot_en = p;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; prot_en = 1'b0;
  endtask

  task automatic wait_lock();
    repeat (L + 2) tick();
  endtask

  task automatic pulse_hard(input bit wdog);
    if (wdog) rst_wdog = 1'b1; else rst_ext = 1'b1;
    tick();
    rst_wdog = 1'b0; rst_ext = 1'b0;
    exp_ratio = 0; exp_div = 0; exp_err = 0;
  endtask

  initial begin
    @(negedge clk);
    tick();
    rst_ext = 1'b0;
    // R1: defaults after external reset
    check_state("R1 ext");
    check("R1 locked", int'(locked), 1);
    check("R1 rd_data", int'(rd_data), 0);

    // Sweep every ratio code with the divider at zero (R4 R5 R6 R9 R11)
    for (int v = 0; v < 32; v++) begin
      do_write(1'b0, v, 1'b1);
      if (v <= 18) begin
        exp_ratio = v;
        tick();
        check_state("R11 sweep");
        check("R6 drop", int'(locked), 0);
        repeat (L - 1) @(posedge clk);
        @(negedge clk);
        check("R6 still unlocked at L", int'(locked), 0);
        tick();
        check("R6 locked at L+1", int'(locked), 1);
      end else begin
        exp_err = 1;
        tick();
        check_state("R5 reject");
        check("R5 no relock", int'(locked), 1);
      end
    end

    // R5: error flag survives valid writes and soft resets, cleared by hard reset
    do_write(1'b0, 7, 1'b1);
    exp_ratio = 7;
    wait_lock();
    check_state("R5 sticky");
    rst_mclk = 1'b1; tick(); rst_mclk = 1'b0; tick();
    check_state("R5 sticky soft");
    pulse_hard(1'b0);
    tick();
    check_state("R5 cleared");

    // Divider sweep with the PLL locked (R8 R9)
    do_write(1'b0, 10, 1'b1);
    exp_ratio = 10;
    wait_lock();
    for (int d = 0; d < 4; d++) begin
      do_write(1'b1, d, 1'b1);
      exp_div = d;
      tick();
      check_state("R8 R9 div sweep");
    end

    // R4: divider nonzero blocks ratio writes, including bad values
    do_write(1'b0, 5, 1'b1);
    tick();
    check_state("R4 blocked");
    do_write(1'b0, 25, 1'b1);
    tick();
    check_state("R4 blocked bad");
    check("R4 lock kept", int'(locked), 1);
    do_write(1'b1, 0, 1'b1);
    exp_div = 0;
    tick();
    check_state("R8 back to zero");

    // R8: nonzero divider rejected while unlocked, zero accepted
    do_write(1'b0, 3, 1'b1);
    exp_ratio = 3;
    tick();
    do_write(1'b1, 2, 1'b1);
    tick();
    check_state("R8 unlocked reject");
    do_write(1'b1, 0, 1'b1);
    tick();
    check_state("R8 zero while unlocked");
    wait_lock();
    do_write(1'b1, 2, 1'b1);
    exp_div = 2;
    tick();
    check_state("R8 after lock");
    do_write(1'b1, 0, 1'b1);
    exp_div = 0;
    tick();

    // R7: rewrite during the count restarts it
    do_write(1'b0, 4, 1'b1);
    repeat (9) tick();
    do_write(1'b0, 6, 1'b1);
    exp_ratio = 6;
    repeat (L) @(posedge clk);
    @(negedge clk);
    check("R7 unlocked at restart L", int'(locked), 0);
    tick();
    check("R7 locked at restart L+1", int'(locked), 1);
    check_state("R7 value");

    // R3: writes without protect enable do nothing
    do_write(1'b0, 9, 1'b0);
    do_write(1'b0, 30, 1'b0);
    do_write(1'b1, 3, 1'b0);
    tick();
    check_state("R3 protected");
    check("R3 lock kept", int'(locked), 1);

    // R10: read port
    rd_sel = 1'b0; tick();
    check("R10 ratio read", int'(rd_data), 6);
    do_write(1'b1, 3, 1'b1);
    exp_div = 3;
    do_write(1'b1, 1, 1'b0);
    rd_sel = 1'b1; tick();
    check("R10 status read", int'(rd_data), 8'h43);

    // R2: debugger and missing-clock resets keep fields, clear rd_data
    rst_dbg = 1'b1; tick();
    check("R2 rd cleared dbg", int'(rd_data), 0);
    rst_dbg = 1'b0; tick();
    check_state("R2 dbg keep");
    check("R2 status after dbg", int'(rd_data), 8'h43);
    rst_mclk = 1'b1; tick();
    check("R2 rd cleared mclk", int'(rd_data), 0);
    rst_mclk = 1'b0; tick();
    check_state("R2 mclk keep");

    // R1: watchdog reset restores defaults
    pulse_hard(1'b1);
    check_state("R1 wdog");
    check("R1 wdog locked", int'(locked), 1);
    check("R1 wdog rd", int'(rd_data), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule